// File: doc/BRIEF.md
# Ternary Successor-Pair Rail Checker

This block watches two ternary check pairs that come from two self-testing ternary cells. A pair is healthy when its second value is the modulo-3 successor of its first. Two separate comparison units examine the pairs, one unit per pair. The first unit sets its output to 1 when its pair is healthy and to 0 otherwise. The second unit sets its output to 2 when its pair is healthy and to 0 otherwise. When both pairs are healthy, the output pair is therefore (1, 2), which is itself a successor pair. Any failure gives (0, 2), (1, 0) or (0, 0), and none of these is a successor pair.

The output pair follows the same convention as the input pairs, so checkers can be stacked into a reduction tree. At each level, the outputs of two lower checkers become the inputs of a higher one. The two outputs come from two independent units, so a single internal fault can corrupt only one of them.

Each comparison unit has a fault-injection input that inverts its successor decision, so the detection path can be exercised in place. Both outputs are registered once, which gives a fixed latency of one clock per tree level.

Top module: `tern_pair_checker`

## Requirements
- R1: A trit is carried on two bits: 2'b00 is 0, 2'b01 is 1 and 2'b10 is 2. The code 2'b11 is illegal.
- R2: One clock after the inputs are sampled, `chk_lo` is 1 if `x0` and `y0` are both legal and `y0` equals (`x0`+1) mod 3. Otherwise `chk_lo` is 0.
- R3: One clock after the inputs are sampled, `chk_hi` is 2 if `x1` and `y1` are both legal and `y1` equals (`x1`+1) mod 3. Otherwise `chk_hi` is 0.
- R4: When both pairs pass, the output pair is (1, 2).
- R5: When either pair fails, `chk_hi` is never (`chk_lo`+1) mod 3.
- R6: A pair with the illegal code on either member fails its test.
- R7: `inj_lo` inverts only the decision behind `chk_lo`, and `inj_hi` inverts only the decision behind `chk_hi`. Neither disturbs the other output.
- R8: While `rst_n` is low, both outputs are 0.
- R9: Feeding the fault-free pair (1, 2) of two earlier checkers into both input pairs gives (1, 2) again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x0 | input | 2 | First member of check pair 0 |
| y0 | input | 2 | Second member of check pair 0 |
| x1 | input | 2 | First member of check pair 1 |
| y1 | input | 2 | Second member of check pair 1 |
| inj_lo | input | 1 | Inverts the pair-0 decision |
| inj_hi | input | 1 | Inverts the pair-1 decision |
| chk_lo | output | 2 | Registered pair-0 result (1 = pass, 0 = fail) |
| chk_hi | output | 2 | Registered pair-1 result (2 = pass, 0 = fail) |

## Verification
Every result appears on the outputs exactly one clock after its inputs are captured. The bench applies each stimulus at a falling edge, lets one rising edge pass, and compares one time unit later against a behavioural integer model. It checks all 256 two-bit input combinations, including the illegal code, with injection off. It then repeats a set of cases under each injection setting and checks the cascade input (1, 2, 1, 2).

// File: rtl/tern_chk_pkg.sv
package tern_chk_pkg;
    localparam int TW = 2;
    typedef logic [TW-1:0] trit_t;
    localparam trit_t T0 = 2'b00;
    localparam trit_t T1 = 2'b01;
    localparam trit_t T2 = 2'b10;

    function automatic logic trit_ok(input trit_t v);
        return v != 2'b11;
    endfunction

    function automatic trit_t trit_inc(input trit_t v);
        case (v)
            T0:      return T1;
            T1:      return T2;
            default: return T0;
        endcase
    endfunction

    function automatic logic is_succ(input trit_t a, input trit_t b);
        return trit_ok(a) && trit_ok(b) && (b == trit_inc(a));
    endfunction
endpackage

// File: rtl/tern_succ_unit.sv
module tern_succ_unit
    import tern_chk_pkg::*;
#(
    parameter trit_t PASS_VAL = T1
) (
    input  trit_t a,
    input  trit_t b,
    input  logic  inj,
    output trit_t k
);
    logic  pass;
    trit_t base;

    always_comb begin
        pass = is_succ(a, b) ^ inj;
        base = T0;
        k    = pass ? PASS_VAL : base;
    end
endmodule

// File: rtl/tern_pair_checker.sv
module tern_pair_checker
    import tern_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] x0,
    input  logic [1:0] y0,
    input  logic [1:0] x1,
    input  logic [1:0] y1,
    input  logic       inj_lo,
    input  logic       inj_hi,
    output logic [1:0] chk_lo,
    output logic [1:0] chk_hi
);
    localparam int NU = 2;
    trit_t xa [NU];
    trit_t ya [NU];
    logic  ia [NU];
    trit_t ka [NU];
    trit_t q  [NU];

    always_comb begin
        xa[0] = x0; ya[0] = y0; ia[0] = inj_lo;
        xa[1] = x1; ya[1] = y1; ia[1] = inj_hi;
    end

    for (genvar g = 0; g < NU; g++) begin : g_unit
        tern_succ_unit #(.PASS_VAL(g == 0 ? T1 : T2)) u_cmp (
            .a(xa[g]), .b(ya[g]), .inj(ia[g]), .k(ka[g])
        );
        always_ff @(posedge clk) begin
            if (!rst_n) q[g] <= T0;
            else        q[g] <= ka[g];
        end
    end

    assign chk_lo = q[0];
    assign chk_hi = q[1];

    // R2
    lo_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_succ(x0, y0) && !inj_lo) |=> chk_lo == T1);
    // R3
    hi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_succ(x1, y1) && !inj_hi) |=> chk_hi == T2);
    // R6
    illegal_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((x0 == 2'b11 || y0 == 2'b11) && !inj_lo) |=> chk_lo == T0);
    // R5
    no_false_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(is_succ(x0, y0) && is_succ(x1, y1)) && !inj_lo && !inj_hi)
        |=> chk_hi != trit_inc(chk_lo));
    // R7
    inj_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_succ(x0, y0) && inj_lo) |=> chk_lo == T0);
endmodule

// File: tb/test_tern_pair_checker.sv
`timescale 1ns/1ps
module test_tern_pair_checker;
    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] x0 = 0, y0 = 0, x1 = 0, y1 = 0;
    logic inj_lo = 0, inj_hi = 0;
    logic [1:0] chk_lo, chk_hi;
    int n_vec = 0, n_bad = 0;

    always #2 clk = ~clk;

    tern_pair_checker i_tern_pair_checker (
        .clk(clk), .rst_n(rst_n), .x0(x0), .y0(y0), .x1(x1), .y1(y1),
        .inj_lo(inj_lo), .inj_hi(inj_hi), .chk_lo(chk_lo), .chk_hi(chk_hi)
    );

    function automatic bit ref_pass(int a, int b);
        if (a > 2 || b > 2) return 0;
        return b == (a + 1) % 3;
    endfunction

    task automatic compare(string req, int elo, int ehi);
        n_vec++;
        if (chk_lo !== 2'(elo) || chk_hi !== 2'(ehi)) begin
            n_bad++;
            $display("FAIL %s: got (%0d,%0d) expected (%0d,%0d)", req, chk_lo, chk_hi, elo, ehi);
        end
    endtask

    task automatic apply(int a0, int b0, int a1, int b1, bit il, bit ih, string req);
        bit p0, p1;
        int elo, ehi;
        @(negedge clk);
        x0 = 2'(a0); y0 = 2'(b0); x1 = 2'(a1); y1 = 2'(b1);
        inj_lo = il; inj_hi = ih;
        p0 = ref_pass(a0, b0) ^ il;
        p1 = ref_pass(a1, b1) ^ ih;
        elo = p0 ? 1 : 0;
        ehi = p1 ? 2 : 0;
        @(posedge clk); #1;
        compare(req, elo, ehi);
        if (!il && !ih && !(ref_pass(a0, b0) && ref_pass(a1, b1)) && (ehi == (elo + 1) % 3)) begin
            n_bad++;
            $display("FAIL R5: model produced successor pair (%0d,%0d) expected non-successor", elo, ehi);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        x0 = 2'd1; y0 = 2'd2; x1 = 2'd1; y1 = 2'd2;
        repeat (3) @(posedge clk);
        #1 compare("R8 reset", 0, 0);
        @(negedge clk); rst_n = 1;
        // R1 R2 R3 R5 R6: every 2-bit combination
        for (int v = 0; v < 256; v++)
            apply(v & 3, (v >> 2) & 3, (v >> 4) & 3, (v >> 6) & 3, 0, 0, "R2/R3/R6");
        // R4: all nine passing combinations
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                apply(a, (a + 1) % 3, b, (b + 1) % 3, 0, 0, "R4");
        // R7: injection on each unit over pass and fail pairs
        for (int v = 0; v < 16; v++) begin
            apply(v & 3, (v >> 2) & 3, 1, 2, 1, 0, "R7 lo");
            apply(0, 1, v & 3, (v >> 2) & 3, 0, 1, "R7 hi");
            apply(v & 3, (v >> 2) & 3, (v >> 2) & 3, v & 3, 1, 1, "R7 both");
        end
        // R9: cascade input from two fault-free checkers
        apply(1, 2, 1, 2, 0, 0, "R9");
        apply(1, 2, 0, 2, 0, 0, "R9 failed lower");
        // R8: reset again mid-run
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1 compare("R8 reset", 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule